// File: doc/BRIEF.md
# Privileged Cycle Counter with Compare Interrupt

This block keeps a free-running cycle count that advances by one on every clock. The count is visible to software through a single register word. The upper bit of that word is a guard flag that decides whether unprivileged code may read the count. A second register holds a compare value and an interrupt-disable flag. When the running count reaches the compare value and the interrupt is enabled, the block emits a one-cycle match pulse and latches a pending-interrupt flag. That flag stays set until software clears it.

Software reaches both registers through one access port. The requester presents a select, a read/write flag, its privilege level and write data. One clock later the block returns a response with the read data and two fault flags. A privileged-action fault means a denied read. A privileged-opcode fault means a denied write. Delivering the trap that follows a fault is left to the surrounding logic.

Top module: `cyc_count_unit`

## Requirements
- R1: After reset the count is 0, the guard flag is 1, the compare word is disable=1 with value 0, and the pending flag, match pulse and response valid are all 0.
- R2: An access presented at a clock edge produces a response at the next cycle. rsp_valid is 1. For a count read, bits 62:0 hold the count as it stood just before that edge and bit 63 holds the guard flag.
- R3: An unprivileged read of the count while the guard flag is 1 returns data 0 with rsp_fault_act=1. While the guard flag is 0 the same read returns the count without a fault.
- R4: A privileged write to the count (acc_sel=0) loads bits 62:0 into the count and bit 63 into the guard flag at that edge. From the next cycle the count advances by one each clock.
- R5: Any unprivileged write, to either register, returns rsp_fault_opc=1 and changes neither register. The count keeps advancing.
- R6: The compare word (acc_sel=1) holds the interrupt-disable flag in bit 63 and the compare value in bits 62:0. A privileged write loads it and a privileged read returns it. An unprivileged read of it always returns data 0 with rsp_fault_act=1.
- R7: When the disable flag is 0 and the count equals the compare value at an edge, match_pulse is 1 for the following cycle only. While the disable flag is 1, no pulse occurs.
- R8: irq_pend is set by every match pulse. It stays set until an edge where irq_clr is 1 and no new match occurs.
- R9: The count wraps from 2^63-1 to 0, and the guard flag is not affected by the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Access request valid this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 1 | 0 = count word, 1 = compare word |
| acc_priv | input | 1 | 1 = requester is privileged |
| acc_wdata | input | CNT_W+1 | Write data word |
| rsp_valid | output | 1 | Response for the access of the previous edge |
| rsp_data | output | CNT_W+1 | Read data, 0 on fault or write |
| rsp_fault_act | output | 1 | Denied read (privileged-action fault) |
| rsp_fault_opc | output | 1 | Denied write (privileged-opcode fault) |
| irq_clr | input | 1 | Clears the pending flag |
| match_pulse | output | 1 | One-cycle count/compare hit |
| irq_pend | output | 1 | Sticky pending interrupt |

## Verification
Every result lands exactly one edge after its cause. A response reflects the access taken at the previous edge, and a count read made n edges after a write of W returns W+n-1 modulo 2^63. The match pulse and the pending flag rise at the edge after the one where the count held the compare value. The bench drives and samples on the falling edge, so it can count edges from each write and predict the cycle in which the match must appear. It checks every cycle of a window around that point, so an early pulse, a late pulse or a repeated pulse is all caught.

// File: rtl/cyc_pkg.sv
package cyc_pkg;
  typedef enum logic {
    SEL_COUNT = 1'b0,
    SEL_CMPR  = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/cyc_counter.sv
module cyc_counter #(
  parameter int unsigned CNT_W = 63
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [CNT_W-1:0] ld_cnt,
  input  logic             ld_guard,
  output logic [CNT_W-1:0] cnt_q,
  output logic             guard_q
);
  logic [CNT_W-1:0] cnt_d;
  logic             guard_d;

  always_comb begin
    cnt_d   = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
    guard_d = guard_q;
    if (ld_en) begin
      cnt_d   = ld_cnt;
      guard_d = ld_guard;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      guard_q <= 1'b1;
    end else begin
      cnt_q   <= cnt_d;
      guard_q <= guard_d;
    end
  end
endmodule

// File: rtl/cyc_compare.sv
module cyc_compare #(
  parameter int unsigned CNT_W = 63
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             ld_dis,
  input  logic [CNT_W-1:0] cnt,
  input  logic             irq_clr,
  output logic [CNT_W-1:0] cmp_q,
  output logic             dis_q,
  output logic             match_q,
  output logic             pend_q
);
  logic [CNT_W-1:0] cmp_d;
  logic             dis_d;
  logic             hit;
  logic             pend_d;

  always_comb begin
    hit    = !dis_q && (cnt == cmp_q);
    pend_d = hit | (pend_q & ~irq_clr);
    cmp_d  = cmp_q;
    dis_d  = dis_q;
    if (ld_en) begin
      cmp_d = ld_val;
      dis_d = ld_dis;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q   <= '0;
      dis_q   <= 1'b1;
      match_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      cmp_q   <= cmp_d;
      dis_q   <= dis_d;
      match_q <= hit;
      pend_q  <= pend_d;
    end
  end
endmodule

// File: rtl/cyc_access.sv
module cyc_access
  import cyc_pkg::*;
#(
  parameter int unsigned CNT_W = 63,
  localparam int unsigned DW   = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_en,
  input  logic             acc_wr,
  input  logic             acc_sel,
  input  logic             acc_priv,
  input  logic [CNT_W-1:0] cnt,
  input  logic             guard,
  input  logic [CNT_W-1:0] cmp,
  input  logic             dis,
  output logic             cnt_ld,
  output logic             cmp_ld,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_data,
  output logic             rsp_fact,
  output logic             rsp_fopc
);
  reg_sel_e         sel;
  logic             is_rd;
  logic             is_wr;
  logic             rd_deny;
  logic             wr_deny;
  logic [DW-1:0]    rd_word;
  logic [DW-1:0]    data_d;

  always_comb begin
    sel     = reg_sel_e'(acc_sel);
    is_rd   = acc_en && !acc_wr;
    is_wr   = acc_en && acc_wr;
    cnt_ld  = is_wr && acc_priv && (sel == SEL_COUNT);
    cmp_ld  = is_wr && acc_priv && (sel == SEL_CMPR);
    wr_deny = is_wr && !acc_priv;
    rd_deny = is_rd && !acc_priv && ((sel == SEL_CMPR) || guard);
    rd_word = (sel == SEL_COUNT) ? {guard, cnt} : {dis, cmp};
    data_d  = (is_rd && !rd_deny) ? rd_word : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_fact  <= 1'b0;
      rsp_fopc  <= 1'b0;
    end else begin
      rsp_valid <= acc_en;
      rsp_data  <= data_d;
      rsp_fact  <= rd_deny;
      rsp_fopc  <= wr_deny;
    end
  end
endmodule

// File: rtl/cyc_count_unit.sv
module cyc_count_unit #(
  parameter int unsigned CNT_W = 63,
  localparam int unsigned DW   = CNT_W + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_en,
  input  logic          acc_wr,
  input  logic          acc_sel,
  input  logic          acc_priv,
  input  logic [DW-1:0] acc_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_fault_act,
  output logic          rsp_fault_opc,
  input  logic          irq_clr,
  output logic          match_pulse,
  output logic          irq_pend
);
  logic [CNT_W-1:0] cnt_q;
  logic             guard_q;
  logic [CNT_W-1:0] cmp_q;
  logic             dis_q;
  logic             cnt_ld;
  logic             cmp_ld;

  cyc_access #(.CNT_W(CNT_W)) u_acc (
    .clk(clk), .rst_n(rst_n),
    .acc_en(acc_en), .acc_wr(acc_wr), .acc_sel(acc_sel), .acc_priv(acc_priv),
    .cnt(cnt_q), .guard(guard_q), .cmp(cmp_q), .dis(dis_q),
    .cnt_ld(cnt_ld), .cmp_ld(cmp_ld),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_fact(rsp_fault_act), .rsp_fopc(rsp_fault_opc)
  );

  cyc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .ld_en(cnt_ld), .ld_cnt(acc_wdata[CNT_W-1:0]), .ld_guard(acc_wdata[CNT_W]),
    .cnt_q(cnt_q), .guard_q(guard_q)
  );

  cyc_compare #(.CNT_W(CNT_W)) u_cmp (
    .clk(clk), .rst_n(rst_n),
    .ld_en(cmp_ld), .ld_val(acc_wdata[CNT_W-1:0]), .ld_dis(acc_wdata[CNT_W]),
    .cnt(cnt_q), .irq_clr(irq_clr),
    .cmp_q(cmp_q), .dis_q(dis_q), .match_q(match_pulse), .pend_q(irq_pend)
  );
endmodule

// File: rtl/cyc_count_unit_chk.sv
module cyc_count_unit_chk #(
  parameter int unsigned CNT_W = 63,
  localparam int unsigned DW   = CNT_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_en,
  input logic             acc_wr,
  input logic             acc_sel,
  input logic             acc_priv,
  input logic [DW-1:0]    acc_wdata,
  input logic [DW-1:0]    rsp_data,
  input logic             rsp_fault_act,
  input logic             rsp_fault_opc,
  input logic             irq_clr,
  input logic             match_pulse,
  input logic             irq_pend,
  input logic [CNT_W-1:0] cnt,
  input logic             guard,
  input logic [CNT_W-1:0] cmp,
  input logic             dis
);
  logic own_cnt_wr;
  assign own_cnt_wr = acc_en && acc_wr && acc_priv && !acc_sel;

  // R3
  a_r3_guarded_read: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_wr && !acc_priv && !acc_sel && guard)
    |=> (rsp_fault_act && rsp_data == '0));

  // R4
  a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
    own_cnt_wr |=> (cnt == $past(acc_wdata[CNT_W-1:0]) && guard == $past(acc_wdata[CNT_W])));

  // R4, R9
  a_r4_advance: assert property (@(posedge clk) disable iff (!rst_n)
    !own_cnt_wr |=> (cnt == $past(cnt) + 1'b1 && $stable(guard)));

  // R5
  a_r5_user_write: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_wr && !acc_priv) |=> (rsp_fault_opc && $stable(cmp) && $stable(dis)));

  // R7
  a_r7_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    dis |=> !match_pulse);

  // R8
  a_r8_pend_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |-> irq_pend);

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend && !irq_clr) |=> irq_pend);
endmodule

bind cyc_count_unit cyc_count_unit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .acc_en(acc_en), .acc_wr(acc_wr), .acc_sel(acc_sel), .acc_priv(acc_priv),
  .acc_wdata(acc_wdata), .rsp_data(rsp_data),
  .rsp_fault_act(rsp_fault_act), .rsp_fault_opc(rsp_fault_opc),
  .irq_clr(irq_clr), .match_pulse(match_pulse), .irq_pend(irq_pend),
  .cnt(cnt_q), .guard(guard_q), .cmp(cmp_q), .dis(dis_q)
);

// File: tb/cyc_count_unit_test.sv
module cyc_count_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_en, acc_wr, acc_sel, acc_priv, irq_clr;
  logic [63:0] acc_wdata;
  logic        rsp_valid, rsp_fault_act, rsp_fault_opc, match_pulse, irq_pend;
  logic [63:0] rsp_data;
  int          total = 0;
  int          bad = 0;
  logic [63:0] cmp_model;

  cyc_count_unit uut (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr), .acc_sel(acc_sel),
    .acc_priv(acc_priv), .acc_wdata(acc_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_fault_act(rsp_fault_act), .rsp_fault_opc(rsp_fault_opc),
    .irq_clr(irq_clr), .match_pulse(match_pulse), .irq_pend(irq_pend)
  );

  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the falling edge after the access edge.
  task automatic access(input logic wr, input logic sel, input logic priv, input logic [63:0] wd);
    acc_en = 1'b1; acc_wr = wr; acc_sel = sel; acc_priv = priv; acc_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0; acc_wdata = '0;
  endtask

  function automatic logic [63:0] cnt_word(input logic g, input logic [62:0] w, input int n);
    logic [62:0] v;
    v = w + 63'(n - 1);
    return {g, v};
  endfunction

  initial begin
    #(4 * 200000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; acc_en = 1'b0; acc_wr = 1'b0; acc_sel = 1'b0; acc_priv = 1'b0;
    acc_wdata = '0; irq_clr = 1'b0;
    cmp_model = {1'b1, 63'd0};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 rsp_valid", {63'd0, rsp_valid}, 64'd0);
    chk("R1 irq_pend", {63'd0, irq_pend}, 64'd0);
    chk("R1 match_pulse", {63'd0, match_pulse}, 64'd0);
    access(1'b0, 1'b0, 1'b1, '0);
    chk("R1 count word", rsp_data, {1'b1, 63'd0});
    access(1'b0, 1'b1, 1'b1, '0);
    chk("R1 compare word", rsp_data, {1'b1, 63'd0});
    access(1'b0, 1'b0, 1'b0, '0);
    chk("R1/R3 guarded at reset", {63'd0, rsp_fault_act}, 64'd1);

    // R2 R3 R5 R6 sweep over privilege, guard, direction and select
    for (int it = 0; it < 16; it++) begin
      logic p, g, w, s, e_act, e_opc;
      logic [62:0] wv;
      logic [63:0] wd, e_data;
      p = it[0]; g = it[1]; w = it[2]; s = it[3];
      wv = 63'(1000 + 37 * it);
      access(1'b1, 1'b0, 1'b1, {g, wv});
      wd = s ? {1'b1, 63'(500 + it)} : {1'b0, 63'(77)};
      access(w, s, p, wd);
      e_opc  = w && !p;
      e_act  = !w && !p && (s || g);
      e_data = (!w && !e_act) ? (s ? cmp_model : {g, wv}) : 64'd0;
      if (w && p && s) cmp_model = wd;
      chk("R2 rsp_valid", {63'd0, rsp_valid}, 64'd1);
      chk("R3/R6 fault_act", {63'd0, rsp_fault_act}, {63'd0, e_act});
      chk("R5 fault_opc", {63'd0, rsp_fault_opc}, {63'd0, e_opc});
      chk("R2/R6 rsp_data", rsp_data, e_data);
    end
    access(1'b0, 1'b1, 1'b1, '0);
    chk("R6 compare readback", rsp_data, cmp_model);

    // R9 wrap, guard clear and set
    for (int gi = 0; gi < 2; gi++) begin
      logic g;
      g = gi[0];
      access(1'b1, 1'b0, 1'b1, {g, {63{1'b1}}});
      access(1'b0, 1'b0, 1'b1, '0);
      chk("R9 top value", rsp_data, {g, {63{1'b1}}});
      access(1'b0, 1'b0, 1'b1, '0);
      chk("R9 wrapped", rsp_data, {g, 63'd0});
    end

    // R4 advance spacing, R5 blocked user write
    access(1'b1, 1'b0, 1'b1, {1'b0, 63'd5000});
    access(1'b1, 1'b0, 1'b0, {1'b1, 63'd9});
    chk("R5 user write faults", {63'd0, rsp_fault_opc}, 64'd1);
    access(1'b0, 1'b0, 1'b1, '0);
    chk("R5 count unchanged", rsp_data, cnt_word(1'b0, 63'd5000, 2));
    repeat (4) @(negedge clk);
    access(1'b0, 1'b0, 1'b0, '0);
    chk("R4 advance by one per cycle", rsp_data, cnt_word(1'b0, 63'd5000, 7));

    // R7 R8 enabled match
    access(1'b1, 1'b0, 1'b1, {1'b0, 63'd100});
    access(1'b1, 1'b1, 1'b1, {1'b0, 63'd110});
    for (int i = 2; i <= 14; i++) begin
      @(posedge clk); @(negedge clk);
      chk("R7 match timing", {63'd0, match_pulse}, {63'd0, (i == 11)});
      chk("R8 pending", {63'd0, irq_pend}, {63'd0, (i >= 11)});
    end
    irq_clr = 1'b1;
    @(posedge clk); @(negedge clk);
    irq_clr = 1'b0;
    chk("R8 cleared", {63'd0, irq_pend}, 64'd0);

    // R7 disabled compare
    access(1'b1, 1'b0, 1'b1, {1'b0, 63'd200});
    access(1'b1, 1'b1, 1'b1, {1'b1, 63'd205});
    for (int i = 2; i <= 10; i++) begin
      @(posedge clk); @(negedge clk);
      chk("R7 no match when disabled", {63'd0, match_pulse}, 64'd0);
    end
    chk("R8 stays clear", {63'd0, irq_pend}, 64'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule